// File: doc/BRIEF.md
# Threshold-Driven Audio Sample FIFO with DMA Request

This block is a word-organised buffer placed between a DMA engine and a serial audio shifter. One instance serves one direction: a playback instance is filled by the DMA engine and drained by the shifter, and a capture instance works the other way round. Every entry holds one word. A 16-bit sample and a 32-bit sample each take one entry, so the capacity in words is set by the depth parameter alone, whatever the sample format.

The block raises a DMA request line from its own fill level, so the DMA engine can move data in bursts. In burst mode the request compares the fill level with a programmed word threshold. Software normally sets that threshold to one audio period expressed in words. In per-word mode the threshold is fixed at one word, so the request asserts whenever a single word can move. The fill level is always visible on a port. Software divides it by the channel count to get the buffering latency in frames.

Both data sides use valid/ready handshakes. A word moves on a rising clock edge when valid and ready are both high. The write side's ready is low exactly when the buffer is full, and the read side's valid is low exactly when it is empty. Neither side's ready or valid depends on the other side's signals in the same cycle.

Top module: `afifo_dreq`

## Requirements
- R1: After reset the fill level is 0, `empty` is 1, `full` is 0, `in_ready` is 1 and `out_valid` is 0. The playback instance's request is high and the capture instance's request is low.
- R2: Words leave in the order they were accepted, bit for bit. The buffer holds exactly DEPTH words.
- R3: While the fill level equals DEPTH, `full` is 1 and `in_ready` is 0. A word offered then is not stored: the fill level stays DEPTH and a later drain returns only the earlier words.
- R4: While the buffer is empty, `out_valid` is 0 and asserting `out_ready` leaves the fill level at 0.
- R5: `fill_level` equals the number of stored words and changes one cycle after a handshake. A push and a pop in the same cycle leave it unchanged.
- R6: In burst mode the capture instance (DIR_TX = 0) asserts `dma_req` exactly when fill level ≥ effective threshold.
- R7: In burst mode the playback instance (DIR_TX = 1) asserts `dma_req` exactly when DEPTH − fill level ≥ effective threshold.
- R8: `cfg_mode` = 0 selects per-word mode, where the effective threshold is 1 whatever the value of `cfg_thresh`. `cfg_mode` = 1 selects burst mode, where the effective threshold comes from `cfg_thresh`.
- R9: In burst mode a `cfg_thresh` of 0 acts as 1, and a `cfg_thresh` above DEPTH acts as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Write side offers a word |
| in_ready | output | 1 | Buffer can accept a word (not full) |
| in_data | input | WORD_W | Word being written |
| out_valid | output | 1 | A word is available (not empty) |
| out_ready | input | 1 | Read side takes the word |
| out_data | output | WORD_W | Oldest stored word |
| cfg_mode | input | 1 | 0 = per-word request, 1 = burst request |
| cfg_thresh | input | CNT_W | Burst threshold in words |
| dma_req | output | 1 | DMA request |
| fill_level | output | CNT_W | Stored word count |
| full | output | 1 | Fill level equals DEPTH |
| empty | output | 1 | Fill level is zero |

## Verification
The assertions hold the following on every cycle:
- The fill level never passes DEPTH.
- The fill level moves by exactly the accepted pushes minus the accepted pops.
- An offer to a full buffer or a pop from an empty one leaves the count untouched.
- In per-word mode the capture request follows non-empty.
- A full buffer never asks for more playback data.
- In burst mode a full capture buffer always requests.

Only the bench's scenarios can show the rest: word order and data integrity across pointer wrap, the exact threshold crossings of both directions while the level is swept up and down, and the clamping of zero and oversize thresholds.

// File: rtl/afifo_dreq_pkg.sv
package afifo_dreq_pkg;
  typedef enum logic {
    REQ_PER_WORD = 1'b0,
    REQ_BURST    = 1'b1
  } req_mode_e;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2  = (DEPTH == (1 << PTR_W));

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if (POW2) begin : g_wrap_natural
      always_comb begin
        wr_nxt = wr_ptr + 1'b1;
        rd_nxt = rd_ptr + 1'b1;
      end
    end else begin : g_wrap_compare
      always_comb begin
        wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/afifo_level.sv
module afifo_level #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (push && !pop) count <= count + 1'b1;
    else if (pop && !push) count <= count - 1'b1;
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // R5: the level never exceeds the capacity
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5: the level tracks accepted pushes and pops
  p_fill_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/afifo_req.sv
module afifo_req
  import afifo_dreq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter bit DIR_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  req_mode_e        mode,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] count,
  output logic             req
);
  logic [CNT_W-1:0] eff_thr;
  logic [CNT_W-1:0] free_words;

  always_comb begin
    if (mode == REQ_PER_WORD)          eff_thr = CNT_W'(1);
    else if (thresh == '0)             eff_thr = CNT_W'(1);
    else if (thresh > CNT_W'(DEPTH))   eff_thr = CNT_W'(DEPTH);
    else                               eff_thr = thresh;
  end

  assign free_words = CNT_W'(DEPTH) - count;

  generate
    if (DIR_TX) begin : g_playback
      assign req = (free_words >= eff_thr);
      // R7: a full playback buffer never asks for data
      p_tx_full_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !req);
    end else begin : g_capture
      assign req = (count >= eff_thr);
      // R8: per-word capture request follows non-empty
      p_rx_word_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_PER_WORD) |-> (req == (count != '0)));
      // R9: a full capture buffer always requests in burst mode
      p_rx_full_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_BURST && count == CNT_W'(DEPTH)) |-> req);
    end
  endgenerate
endmodule

// File: rtl/afifo_dreq.sv
module afifo_dreq
  import afifo_dreq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128,
  parameter bit DIR_TX = 1'b1,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  input  logic              cfg_mode,
  input  logic [CNT_W-1:0]  cfg_thresh,
  output logic              dma_req,
  output logic [CNT_W-1:0]  fill_level,
  output logic              full,
  output logic              empty
);
  logic      push, pop;
  req_mode_e mode;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push      = in_valid && !full;
  assign pop       = out_ready && !empty;
  assign mode      = req_mode_e'(cfg_mode);

  afifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_data(in_data), .rd_data(out_data)
  );

  afifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .count(fill_level), .full(full), .empty(empty)
  );

  afifo_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIR_TX(DIR_TX)) u_req (
    .clk(clk), .rst_n(rst_n), .mode(mode), .thresh(cfg_thresh),
    .count(fill_level), .req(dma_req)
  );

  // R3: an offer to a full buffer does not raise the level
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready) |=> (fill_level == CNT_W'(DEPTH)));

  // R4: a pop request on an empty buffer does not lower the level
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && out_ready && !in_valid) |=> (fill_level == '0));
endmodule

// File: tb/afifo_dreq_bench.sv
module afifo_dreq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 16;
  localparam int D     = 16;
  localparam int CW    = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, cfg_mode = 1'b1;
  logic [W-1:0]  in_data = '0;
  logic [CW-1:0] cfg_thresh = CW'(4);

  logic rx_in_ready, rx_out_valid, rx_req, rx_full, rx_empty;
  logic tx_in_ready, tx_out_valid, tx_req, tx_full, tx_empty;
  logic [W-1:0]  rx_out_data, tx_out_data;
  logic [CW-1:0] rx_fill, tx_fill;

  int checks = 0, fails = 0;
  logic [W-1:0] model_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  afifo_dreq #(.WORD_W(W), .DEPTH(D), .DIR_TX(1'b0)) u_afifo_dreq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rx_in_ready),
    .in_data(in_data), .out_valid(rx_out_valid), .out_ready(out_ready),
    .out_data(rx_out_data), .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh),
    .dma_req(rx_req), .fill_level(rx_fill), .full(rx_full), .empty(rx_empty));

  afifo_dreq #(.WORD_W(W), .DEPTH(D), .DIR_TX(1'b1)) u_afifo_dreq_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(tx_in_ready),
    .in_data(in_data), .out_valid(tx_out_valid), .out_ready(out_ready),
    .out_data(tx_out_data), .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh),
    .dma_req(tx_req), .fill_level(tx_fill), .full(tx_full), .empty(tx_empty));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_thr();
    if (cfg_mode == 1'b0) return 1;
    if (cfg_thresh == 0) return 1;
    if (int'(cfg_thresh) > D) return D;
    return int'(cfg_thresh);
  endfunction

  task automatic check_req(string tag);
    int n = model_q.size();
    check({tag, " rx req (R6)"}, {31'd0, rx_req}, {31'd0, n >= eff_thr()});
    check({tag, " tx req (R7)"}, {31'd0, tx_req}, {31'd0, (D - n) >= eff_thr()});
  endtask

  // one clock with optional push and pop; inputs change 1 time unit after the edge
  task automatic cycle(bit do_push, logic [W-1:0] d, bit do_pop);
    bit push_ok = do_push && (model_q.size() < D);
    bit pop_ok  = do_pop && (model_q.size() > 0);
    logic [W-1:0] head = '0;
    in_valid = do_push; in_data = d; out_ready = do_pop;
    if (pop_ok) begin
      head = model_q[0];
      check("R2 rx order", {16'd0, rx_out_data}, {16'd0, head});
      check("R2 tx order", {16'd0, tx_out_data}, {16'd0, head});
    end
    @(posedge clk); #1;
    if (pop_ok)  void'(model_q.pop_front());
    if (push_ok) model_q.push_back(d);
    in_valid = 1'b0; out_ready = 1'b0;
    check("R5 fill", {27'd0, rx_fill}, {27'd0, 5'(model_q.size())});
    check("R5 tx fill", {27'd0, tx_fill}, {27'd0, 5'(model_q.size())});
  endtask

  task automatic t_reset();
    check("R1 fill", {27'd0, rx_fill}, 0);
    check("R1 empty", {31'd0, rx_empty}, 1);
    check("R1 full", {31'd0, rx_full}, 0);
    check("R1 in_ready", {31'd0, rx_in_ready}, 1);
    check("R1 out_valid", {31'd0, rx_out_valid}, 0);
    check("R1 rx req", {31'd0, rx_req}, 0);
    check("R1 tx req", {31'd0, tx_req}, 1);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < D; i++) cycle(1'b1, W'(16'hA500 + i), 1'b0);
    check("R3 full", {31'd0, rx_full}, 1);
    check("R3 in_ready", {31'd0, rx_in_ready}, 0);
    cycle(1'b1, W'(16'hDEAD), 1'b0);
    check("R3 level held", {27'd0, rx_fill}, D);
    for (int i = 0; i < D; i++) cycle(1'b0, '0, 1'b1);
    check("R4 empty", {31'd0, rx_empty}, 1);
    check("R4 out_valid", {31'd0, rx_out_valid}, 0);
    cycle(1'b0, '0, 1'b1);
    check("R4 level held", {27'd0, rx_fill}, 0);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) cycle(1'b1, W'(16'h1000 + i), 1'b0);
    for (int i = 0; i < 20; i++) cycle(1'b1, W'(16'h2000 + i * 7), 1'b1);
    check("R5 level steady", {27'd0, rx_fill}, 3);
    while (model_q.size() > 0) cycle(1'b0, '0, 1'b1);
  endtask

  task automatic sweep(string tag);
    check_req(tag);
    for (int i = 0; i < D; i++) begin
      cycle(1'b1, W'(16'h3000 + i), 1'b0);
      check_req(tag);
    end
    for (int i = 0; i < D; i++) begin
      cycle(1'b0, '0, 1'b1);
      check_req(tag);
    end
  endtask

  task automatic t_burst();
    cfg_mode = 1'b1; cfg_thresh = CW'(5); #1;
    sweep("burst T5");
  endtask

  task automatic t_per_word();
    cfg_mode = 1'b0; cfg_thresh = CW'(9); #1;
    sweep("R8 per-word");
  endtask

  task automatic t_clamp();
    cfg_mode = 1'b1; cfg_thresh = '0; #1;
    sweep("R9 zero");
    cfg_mode = 1'b1; cfg_thresh = CW'(31); #1;
    sweep("R9 over");
  endtask

  initial begin
    bit done = 1'b0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill_drain();
        t_simul();
        t_burst();
        t_per_word();
        t_clamp();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
      end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule